// File: doc/BRIEF.md
# One-Time-Programmable Memory Mode Controller

This block is a cycle-level model of the control side of a 128K-word by 16-bit one-time-programmable memory. On every rising clock edge it samples five control inputs and the address. The control inputs are an active-low chip select, an active-low output gate, an active-low write strobe, a flag that marks the programming supply as raised, and a flag that marks an overvoltage on address line 9. From these it selects one of seven modes. The selected mode sets what the block does in that cycle: it drives a stored word, drives an identification word, writes into the array, or keeps its outputs off.

The tri-state data bus is modelled as a 16-bit value with a separate enable. The value is forced to zero whenever the enable is low. The storage is a small register array of `MEM_DEPTH` words, indexed by the low address bits. The upper address bits alias onto it. Cells start erased at all ones, and a write can only clear bits. The identification words are parameters.

The decoded mode is a state, registered every cycle. The named states and their 3-bit codes are STANDBY (0), READ (1), OUTDIS (2), PROGRAM (3), VERIFY (4), INHIBIT (5) and IDENT (6). From any state, the next state is chosen only by the current inputs, using the priority in R2 to R10. There is no sequencing between states.

Top module: `otp_mode_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets mode to STANDBY (0), dout_en to 0 and dout to 0, and erases every array word to 0xFFFF.
- R2: With ce_n high and vpp_hi low, the next state is STANDBY (0) and dout_en is 0, whatever oe_n, pgm_n, a9_hv, addr and din are.
- R3: With ce_n low, oe_n low, vpp_hi low and no valid identification request, the next state is READ (1), dout_en is 1 and dout is the word at index addr[MEM_AW-1:0].
- R4: With ce_n low, oe_n high and no program condition, the next state is OUTDIS (2), dout_en is 0 and the array is not written.
- R5: With ce_n low, oe_n high, pgm_n low and vpp_hi high, the next state is PROGRAM (3) and dout_en is 0. The addressed word becomes its old value ANDed with din, so no bit ever changes from 0 to 1.
- R6: With ce_n low, oe_n low, pgm_n high and vpp_hi high, the next state is VERIFY (4), dout_en is 1 and dout is the stored word.
- R7: With ce_n high and vpp_hi high, the next state is INHIBIT (5), dout_en is 0 and no word is written, even with pgm_n low.
- R8: With ce_n low, oe_n low, vpp_hi low, a9_hv high and addr[16:1] all zero, the next state is IDENT (6) and dout_en is 1. dout is MFR_CODE (0x001E) when addr[0] is 0 and DEV_CODE (0x00F7) when addr[0] is 1.
- R9: If a9_hv is high but any of addr[16:1] is 1, the controller takes READ (1) and returns the array word.
- R10: With ce_n low, oe_n low, pgm_n low and vpp_hi high, the next state is OUTDIS (2), dout_en is 0 and no write occurs.
- R11: All outputs change only at the rising edge that samples the inputs, and dout is 0 whenever dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Write strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | Overvoltage present on address line 9 |
| addr | input | ADDR_W (17) | Word address |
| din | input | DATA_W (16) | Word to program |
| dout | output | DATA_W (16) | Data bus value, zero when not driven |
| dout_en | output | 1 | Data bus drive enable |
| mode | output | 3 | Registered state code |

## Verification
All three outputs (mode, dout_en and dout) are due at the first rising edge after the inputs are applied. A write made at that edge is visible at the next edge that reads the same index. The bench changes inputs at a falling edge and samples at the following falling edge, so exactly one rising edge lies between stimulus and check. One check samples before that edge, to confirm the outputs have not yet moved. The "ignored" cases (inhibit, output-disable, illegal strobe and a 0-to-1 write attempt) are each followed by a read of the same word through the data port.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [2:0] {
        M_STANDBY = 3'd0,
        M_READ    = 3'd1,
        M_OUTDIS  = 3'd2,
        M_PROGRAM = 3'd3,
        M_VERIFY  = 3'd4,
        M_INHIBIT = 3'd5,
        M_IDENT   = 3'd6
    } otp_mode_e;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    output otp_mode_e         next_mode
);
    logic upper_clear;

    assign upper_clear = (addr[ADDR_W-1:1] == '0);

    // Priority: chip select, then output gate, then programming supply.
    always_comb begin
        if (ce_n) begin
            next_mode = vpp_hi ? M_INHIBIT : M_STANDBY;
        end else if (oe_n) begin
            next_mode = (vpp_hi && !pgm_n) ? M_PROGRAM : M_OUTDIS;
        end else if (vpp_hi) begin
            next_mode = pgm_n ? M_VERIFY : M_OUTDIS;
        end else if (a9_hv && upper_clear) begin
            next_mode = M_IDENT;
        end else begin
            next_mode = M_READ;
        end
    end
endmodule

// File: rtl/otp_array.sv
module otp_array #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= '1;
            end else if (wr_en && (idx == AW'(g))) begin
                cells[g] <= cells[g] & wdata;
            end
        end
    end

    assign rdata = cells[idx];
endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
    import otp_pkg::*;
#(
    parameter int          ADDR_W    = 17,
    parameter int          DATA_W    = 16,
    parameter int          MEM_DEPTH = 64,
    parameter logic [15:0] MFR_CODE  = 16'h001E,
    parameter logic [15:0] DEV_CODE  = 16'h00F7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic [2:0]        mode
);
    localparam int MEM_AW = $clog2(MEM_DEPTH);

    otp_mode_e         next_mode;
    otp_mode_e         mode_q;
    logic [DATA_W-1:0] word_rd;
    logic [DATA_W-1:0] dout_q;
    logic              en_q;

    otp_mode_decode #(.ADDR_W(ADDR_W)) u_decode (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .pgm_n     (pgm_n),
        .vpp_hi    (vpp_hi),
        .a9_hv     (a9_hv),
        .addr      (addr),
        .next_mode (next_mode)
    );

    otp_array #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (next_mode == M_PROGRAM),
        .idx   (addr[MEM_AW-1:0]),
        .wdata (din),
        .rdata (word_rd)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= M_STANDBY;
        end else begin
            mode_q <= next_mode;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            en_q   <= 1'b0;
        end else begin
            unique case (next_mode)
                M_READ, M_VERIFY: begin
                    dout_q <= word_rd;
                    en_q   <= 1'b1;
                end
                M_IDENT: begin
                    dout_q <= addr[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);
                    en_q   <= 1'b1;
                end
                M_STANDBY, M_OUTDIS, M_PROGRAM, M_INHIBIT: begin
                    dout_q <= '0;
                    en_q   <= 1'b0;
                end
                default: begin
                    dout_q <= '0;
                    en_q   <= 1'b0;
                end
            endcase
        end
    end

    assign dout    = dout_q;
    assign dout_en = en_q;
    assign mode    = mode_q;
endmodule

// File: rtl/otp_mode_ctrl_chk.sv
module otp_mode_ctrl_chk #(
    parameter int          ADDR_W   = 17,
    parameter int          DATA_W   = 16,
    parameter logic [15:0] MFR_CODE = 16'h001E,
    parameter logic [15:0] DEV_CODE = 16'h00F7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              pgm_n,
    input logic              vpp_hi,
    input logic              a9_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic [2:0]        mode
);
    // R2
    standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_hi) |=> (mode == 3'd0 && !dout_en));

    // R7
    inhibit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && vpp_hi) |=> (mode == 3'd5 && !dout_en));

    // R4
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dout_en);

    // R10
    illegal_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !pgm_n && vpp_hi) |=> (mode == 3'd2 && !dout_en));

    // R8
    ident_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_hi && a9_hv && addr[ADDR_W-1:1] == '0)
        |=> (mode == 3'd6 && dout_en &&
             dout == ($past(addr[0]) ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE))));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == '0);

    // R3
    drive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (mode == 3'd1 || mode == 3'd4 || mode == 3'd6));
endmodule

bind otp_mode_ctrl otp_mode_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .dout(dout),
    .dout_en(dout_en), .mode(mode)
);

// File: tb/otp_mode_ctrl_tb.sv
module otp_mode_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0;
    logic [16:0] addr = '0;
    logic [15:0] din = '1;
    logic [15:0] dout;
    logic        dout_en;
    logic [2:0]  mode;
    int          n_checks = 0;
    int          n_errors = 0;

    always #2 clk = ~clk;

    otp_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .mode(mode)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply at a falling edge; outputs are sampled at the next falling edge.
    task automatic step(input logic c, input logic o, input logic p, input logic v,
                        input logic h, input logic [16:0] a, input logic [15:0] d);
        ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a9_hv = h; addr = a; din = d;
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [2:0] m,
                              input logic en, input logic [15:0] d);
        check({tag, " mode"}, 16'(mode), 16'(m));
        check({tag, " en"},   16'(dout_en), 16'(en));
        check({tag, " data"}, dout, d);
    endtask

    task automatic t_reset();
        expect_out("R1 reset", 3'd0, 1'b0, 16'h0000);
        step(0, 0, 1, 0, 0, 17'd7, 16'hFFFF);
        expect_out("R1 erased word", 3'd1, 1'b1, 16'hFFFF);
    endtask

    task automatic t_latency();
        step(1, 1, 1, 0, 0, 17'd0, 16'hFFFF);
        ce_n = 0; oe_n = 0; addr = 17'd3;
        #1;
        check("R11 before edge en", 16'(dout_en), 16'd0);
        @(negedge clk);
        check("R11 after edge en", 16'(dout_en), 16'd1);
    endtask

    task automatic t_program();
        step(0, 1, 0, 1, 0, 17'd5, 16'hF0F0);
        expect_out("R5 program", 3'd3, 1'b0, 16'h0000);
        step(0, 0, 1, 0, 0, 17'd5, 16'hFFFF);
        expect_out("R3 read back", 3'd1, 1'b1, 16'hF0F0);
        step(0, 1, 0, 1, 0, 17'd5, 16'h0FFF);
        step(0, 0, 1, 1, 0, 17'd5, 16'hFFFF);
        expect_out("R6 verify", 3'd4, 1'b1, 16'h00F0);
        step(0, 1, 0, 1, 0, 17'd5, 16'hFFFF);
        step(0, 0, 1, 0, 0, 17'd5, 16'hFFFF);
        expect_out("R5 no 0-to-1", 3'd1, 1'b1, 16'h00F0);
    endtask

    task automatic t_no_write();
        step(1, 1, 0, 1, 0, 17'd5, 16'h0000);
        expect_out("R7 inhibit", 3'd5, 1'b0, 16'h0000);
        step(0, 0, 1, 0, 0, 17'd5, 16'hFFFF);
        expect_out("R7 word kept", 3'd1, 1'b1, 16'h00F0);
        step(0, 1, 0, 0, 0, 17'd5, 16'h0000);
        expect_out("R4 outdis", 3'd2, 1'b0, 16'h0000);
        step(0, 0, 1, 0, 0, 17'd5, 16'hFFFF);
        expect_out("R4 word kept", 3'd1, 1'b1, 16'h00F0);
        step(0, 0, 0, 1, 0, 17'd5, 16'h0000);
        expect_out("R10 illegal", 3'd2, 1'b0, 16'h0000);
        step(0, 0, 1, 0, 0, 17'd5, 16'hFFFF);
        expect_out("R10 word kept", 3'd1, 1'b1, 16'h00F0);
        step(1, 0, 0, 0, 1, 17'd5, 16'h0000);
        expect_out("R2 standby", 3'd0, 1'b0, 16'h0000);
    endtask

    task automatic t_ident();
        step(0, 0, 1, 0, 1, 17'd0, 16'hFFFF);
        expect_out("R8 maker word", 3'd6, 1'b1, 16'h001E);
        step(0, 0, 1, 0, 1, 17'd1, 16'hFFFF);
        expect_out("R8 device word", 3'd6, 1'b1, 16'h00F7);
        step(0, 0, 1, 0, 1, 17'h00205, 16'hFFFF);
        expect_out("R9 blocked ident", 3'd1, 1'b1, 16'h00F0);
        step(0, 0, 1, 0, 1, 17'h10000, 16'hFFFF);
        expect_out("R9 high bit set", 3'd1, 1'b1, 16'hFFFF);
    endtask

    function automatic logic [2:0] ref_mode(input logic c, input logic o, input logic p,
                                            input logic v, input logic h);
        if (c)      return v ? 3'd5 : 3'd0;
        else if (o) return (v && !p) ? 3'd3 : 3'd2;
        else if (v) return p ? 3'd4 : 3'd2;
        else        return h ? 3'd6 : 3'd1;
    endfunction

    task automatic t_table();
        for (int i = 0; i < 32; i++) begin
            logic [4:0] b;
            logic [2:0] m;
            b = 5'(i);
            step(b[4], b[3], b[2], b[1], b[0], 17'd0, 16'hFFFF);
            m = ref_mode(b[4], b[3], b[2], b[1], b[0]);
            check($sformatf("R2-table R3 R4 R5 R6 R7 R8 combo %0d mode", i), 16'(mode), 16'(m));
            check($sformatf("R11 combo %0d en", i), 16'(dout_en),
                  16'(m == 3'd1 || m == 3'd4 || m == 3'd6));
        end
    endtask

    initial begin
        #400000;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_program();
        t_no_write();
        t_ident();
        t_table();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule